// File: doc/BRIEF.md
# Processor exception entry unit

This block performs the state changes that a 32-bit processor with branch delay slots makes when an instruction faults. A single-cycle request carries a fault kind, the PC and next PC of the faulting instruction, the offending virtual address, the current address-space identifier and a coprocessor number. On the following clock edge the unit saves a restart address corrected for the delay slot, records the cause, enters exception level, may rotate the shadow register set selectors, captures translation-fault details, and redirects the fetch stream to the selected handler.

The handler address depends on the fault kind, on the bootstrap-vector bit, on the exception-level bit as it stood before entry, and on the vectored-interrupt bit. A small write port lets the surrounding pipeline load the status bits, the interrupt-vectoring bit, the shadow set selectors and the exception base, so that the conditions of each vector are reachable. The translation buffer, decode and the return-from-exception path sit outside this block.

Top module: `exc_entry`

## Requirements
- R1: The fault kind input selects the recorded cause code: kind 0 gives 0x1, kinds 1 and 3 give 0x2, kinds 2 and 4 give 0x3, kind 5 gives 0x4, kind 6 gives 0x5, kind 7 gives 0x8, kind 8 gives 0x9, kinds 9 (interrupt) and 10 give 0xA, kind 11 (coprocessor unusable) gives 0xB, kind 12 (overflow) gives 0xC, kind 13 gives 0xD. Kinds 1 and 2 are refill faults; kinds 0 to 4 are translation faults; kinds 5 and 6 are address errors.
- R2: When pc_in + 4 differs from npc_in (modulo 2^32), epc becomes pc_in - 4 and cause_bd becomes 1; otherwise epc becomes pc_in and cause_bd becomes 0.
- R3: Every accepted fault sets status_exl to 1, also when it was already 1.
- R4: Only when status_exl and status_bev are both 0 before entry does pss take the old css and css take ess; otherwise both stay unchanged. ess never changes on entry.
- R5: cause_ce is cleared on every accepted fault, except that a coprocessor-unusable fault loads it with cop_num.
- R6: A refill fault vectors to ebase + 0x000 if status_exl was 0 before entry and to ebase + 0x180 if it was 1.
- R7: An interrupt with cause_iv = 1 vectors to ebase + 0x200; every other fault not covered by R6 or R8 vectors to ebase + 0x180.
- R8: An overflow fault taken while status_bev = 1 vectors to 0xBFC00200.
- R9: Translation faults load badvaddr with bad_vaddr, ehi_vpn2 and ctx_vpn2 with bad_vaddr[31:13] and ehi_asid with asid_in; address errors load only badvaddr; other faults leave all four unchanged.
- R10: All updates appear on the edge after the request; exc_pending is 1 for exactly the cycle after each accepted request; new_npc = new_pc + 4 and new_nnpc = new_pc + 8.
- R11: After reset ebase = 0x80000000, status_bev = 1, new_pc = 0 and every other register output is 0. ebase bits 31:30 always read 2'b10 and bits 11:0 read 0.
- R12: With wr_en = 1 and no accepted request, wr_sel 0 loads status_exl from wr_data[0] and status_bev from wr_data[1]; wr_sel 1 loads cause_iv from wr_data[0]; wr_sel 2 loads ess, css and pss from wr_data[3:0], [7:4] and [11:8]; wr_sel 3 loads ebase[29:12] from wr_data[29:12]; other selects change nothing. A write in the same cycle as an accepted request is dropped.
- R13: Requests with kind 14 or 15 are ignored: no output changes and exc_pending stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Fault request, one cycle |
| kind | input | 4 | Fault kind (R1) |
| pc_in | input | 32 | PC of the faulting instruction |
| npc_in | input | 32 | Next PC at the time of the fault |
| bad_vaddr | input | 32 | Offending virtual address |
| asid_in | input | ASID_W | Current address-space identifier |
| cop_num | input | CP_W | Coprocessor that raised the fault |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register write select |
| wr_data | input | 32 | Register write data |
| exc_pending | output | 1 | Entry committed in the previous edge |
| new_pc | output | 32 | Handler address |
| new_npc | output | 32 | Handler address + 4 |
| new_nnpc | output | 32 | Handler address + 8 |
| epc | output | 32 | Saved restart address |
| cause_code | output | 5 | Recorded cause code |
| cause_bd | output | 1 | Delay-slot flag |
| cause_ce | output | CP_W | Coprocessor error number |
| cause_iv | output | 1 | Vectored-interrupt enable |
| status_exl | output | 1 | Exception-level bit |
| status_bev | output | 1 | Bootstrap-vector bit |
| css | output | SRS_W | Current shadow set |
| pss | output | SRS_W | Previous shadow set |
| ess | output | SRS_W | Exception shadow set |
| ebase | output | 32 | Exception base |
| badvaddr | output | 32 | Captured faulting address |
| ehi_vpn2 | output | 19 | Page-pair number of the translation entry |
| ehi_asid | output | ASID_W | Identifier of the translation entry |
| ctx_vpn2 | output | 19 | Page-pair number in the context register |

## Verification
The hardest cases to reach are those where the pre-entry exception level decides the result: a refill taken while already at exception level, and the shadow set rotation that happens only with both level and bootstrap bits clear. Since entry always sets the level bit and nothing but the write port clears it, the random stimulus interleaves status writes with faults so that nested and first-level entries, with the bootstrap bit either way, all occur; directed cases then pin a nested refill, a bootstrap overflow, a vectored interrupt and a write colliding with a fault.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int ASID_W = 8,
  parameter int SRS_W  = 4,
  parameter int CP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [3:0]        kind,
  input  logic [31:0]       pc_in,
  input  logic [31:0]       npc_in,
  input  logic [31:0]       bad_vaddr,
  input  logic [ASID_W-1:0] asid_in,
  input  logic [CP_W-1:0]   cop_num,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic              exc_pending,
  output logic [31:0]       new_pc,
  output logic [31:0]       new_npc,
  output logic [31:0]       new_nnpc,
  output logic [31:0]       epc,
  output logic [4:0]        cause_code,
  output logic              cause_bd,
  output logic [CP_W-1:0]   cause_ce,
  output logic              cause_iv,
  output logic              status_exl,
  output logic              status_bev,
  output logic [SRS_W-1:0]  css,
  output logic [SRS_W-1:0]  pss,
  output logic [SRS_W-1:0]  ess,
  output logic [31:0]       ebase,
  output logic [31:0]       badvaddr,
  output logic [18:0]       ehi_vpn2,
  output logic [ASID_W-1:0] ehi_asid,
  output logic [18:0]       ctx_vpn2
);
  localparam logic [31:0] BOOT_OVF_VEC = 32'hBFC0_0200;
  localparam logic [31:0] OFS_GEN      = 32'h180;
  localparam logic [31:0] OFS_INT      = 32'h200;

  logic       valid, is_tlb, is_refill, is_addr, is_int, is_cop, is_ovf;
  logic [4:0] code;
  logic [31:0] vec, ebase_q;
  logic [17:0] ebase_mid;
  logic       in_slot, take;

  always_comb begin
    valid = 1'b1; is_tlb = 1'b0; is_refill = 1'b0; is_addr = 1'b0;
    is_int = 1'b0; is_cop = 1'b0; is_ovf = 1'b0; code = 5'h0;
    case (kind)
      4'd0:  begin code = 5'h1; is_tlb = 1'b1; end
      4'd1:  begin code = 5'h2; is_tlb = 1'b1; is_refill = 1'b1; end
      4'd2:  begin code = 5'h3; is_tlb = 1'b1; is_refill = 1'b1; end
      4'd3:  begin code = 5'h2; is_tlb = 1'b1; end
      4'd4:  begin code = 5'h3; is_tlb = 1'b1; end
      4'd5:  begin code = 5'h4; is_addr = 1'b1; end
      4'd6:  begin code = 5'h5; is_addr = 1'b1; end
      4'd7:  code = 5'h8;
      4'd8:  code = 5'h9;
      4'd9:  begin code = 5'hA; is_int = 1'b1; end
      4'd10: code = 5'hA;
      4'd11: begin code = 5'hB; is_cop = 1'b1; end
      4'd12: begin code = 5'hC; is_ovf = 1'b1; end
      4'd13: code = 5'hD;
      default: valid = 1'b0;
    endcase
  end

  assign ebase_q = {2'b10, ebase_mid, 12'h000};
  assign ebase   = ebase_q;
  assign take    = req && valid;
  assign in_slot = (pc_in + 32'd4) != npc_in;

  always_comb begin
    if (is_refill)                vec = status_exl ? ebase_q + OFS_GEN : ebase_q;
    else if (is_int && cause_iv)  vec = ebase_q + OFS_INT;
    else if (is_ovf && status_bev) vec = BOOT_OVF_VEC;
    else                          vec = ebase_q + OFS_GEN;
  end

  assign new_npc  = new_pc + 32'd4;
  assign new_nnpc = new_pc + 32'd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_pending <= 1'b0;
      new_pc <= '0; epc <= '0; cause_code <= '0; cause_bd <= 1'b0;
      cause_ce <= '0; cause_iv <= 1'b0; status_exl <= 1'b0; status_bev <= 1'b1;
      css <= '0; pss <= '0; ess <= '0; ebase_mid <= '0;
      badvaddr <= '0; ehi_vpn2 <= '0; ehi_asid <= '0; ctx_vpn2 <= '0;
    end else begin
      exc_pending <= take;
      if (take) begin
        new_pc     <= vec;
        epc        <= in_slot ? pc_in - 32'd4 : pc_in;
        cause_bd   <= in_slot;
        cause_code <= code;
        cause_ce   <= is_cop ? cop_num : '0;
        status_exl <= 1'b1;
        if (!status_exl && !status_bev) begin
          pss <= css;
          css <= ess;
        end
        if (is_tlb || is_addr) badvaddr <= bad_vaddr;
        if (is_tlb) begin
          ehi_vpn2 <= bad_vaddr[31:13];
          ehi_asid <= asid_in;
          ctx_vpn2 <= bad_vaddr[31:13];
        end
      end else if (wr_en) begin
        case (wr_sel)
          2'd0: begin status_exl <= wr_data[0]; status_bev <= wr_data[1]; end
          2'd1: cause_iv <= wr_data[0];
          2'd2: begin
            ess <= wr_data[SRS_W-1:0];
            css <= wr_data[4+SRS_W-1:4];
            pss <= wr_data[8+SRS_W-1:8];
          end
          default: ebase_mid <= wr_data[29:12];
        endcase
      end
    end
  end

  assert_exl_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending |-> status_exl);

  assert_bd_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending |-> cause_bd == (($past(pc_in) + 32'd4) != $past(npc_in)));

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pending && ($past(status_exl) || $past(status_bev)))
      |-> (css == $past(css) && pss == $past(pss)));

  assert_ce_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pending && cause_code != 5'hB) |-> cause_ce == '0);

  assert_ebase_form_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ebase[31:30] == 2'b10 && ebase[11:0] == 12'h000);

  assert_no_entry_bad_kind_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req && kind >= 4'd14) |=> !exc_pending);
endmodule

// File: tb/test_exc_entry.sv
module test_exc_entry;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr_en = 1'b0;
  logic [3:0] kind = '0;
  logic [31:0] pc_in = '0, npc_in = '0, bad_vaddr = '0, wr_data = '0;
  logic [7:0] asid_in = '0;
  logic [1:0] cop_num = '0, wr_sel = '0;
  logic exc_pending, cause_bd, cause_iv, status_exl, status_bev;
  logic [31:0] new_pc, new_npc, new_nnpc, epc, ebase, badvaddr;
  logic [4:0] cause_code;
  logic [1:0] cause_ce;
  logic [3:0] css, pss, ess;
  logic [18:0] ehi_vpn2, ctx_vpn2;
  logic [7:0] ehi_asid;

  exc_entry i_exc_entry (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [31:0] m_pc, m_epc, m_ebase, m_bva;
  logic [4:0] m_code;
  logic m_bd, m_iv, m_exl, m_bev, m_pend;
  logic [1:0] m_ce;
  logic [3:0] m_css, m_pss, m_ess;
  logic [18:0] m_vpn2, m_ctx;
  logic [7:0] m_asid;

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [4:0] code_of(logic [3:0] k);
    case (k)
      0: return 5'h1; 1, 3: return 5'h2; 2, 4: return 5'h3;
      5: return 5'h4; 6: return 5'h5; 7: return 5'h8; 8: return 5'h9;
      9, 10: return 5'hA; 11: return 5'hB; 12: return 5'hC; 13: return 5'hD;
      default: return 5'h0;
    endcase
  endfunction

  function automatic logic [31:0] vec_of(logic [3:0] k, logic exl, logic bev,
                                         logic iv, logic [31:0] base);
    if (k == 1 || k == 2) return exl ? base + 32'h180 : base;
    if (k == 9 && iv) return base + 32'h200;
    if (k == 12 && bev) return 32'hBFC00200;
    return base + 32'h180;
  endfunction

  function automatic string vtag(logic [3:0] k);
    if (k == 1 || k == 2) return "R6";
    if (k == 12) return "R8";
    return "R7";
  endfunction

  task automatic reset_model();
    m_pc = 0; m_epc = 0; m_ebase = 32'h80000000; m_bva = 0; m_code = 0;
    m_bd = 0; m_iv = 0; m_exl = 0; m_bev = 1; m_pend = 0; m_ce = 0;
    m_css = 0; m_pss = 0; m_ess = 0; m_vpn2 = 0; m_ctx = 0; m_asid = 0;
  endtask

  task automatic check_all(string vt);
    chk("R10", "exc_pending", {31'b0, exc_pending}, {31'b0, m_pend});
    chk(vt,    "new_pc", new_pc, m_pc);
    chk("R10", "new_npc", new_npc, m_pc + 4);
    chk("R10", "new_nnpc", new_nnpc, m_pc + 8);
    chk("R2",  "epc", epc, m_epc);
    chk("R2",  "cause_bd", {31'b0, cause_bd}, {31'b0, m_bd});
    chk("R1",  "cause_code", {27'b0, cause_code}, {27'b0, m_code});
    chk("R5",  "cause_ce", {30'b0, cause_ce}, {30'b0, m_ce});
    chk("R12", "cause_iv", {31'b0, cause_iv}, {31'b0, m_iv});
    chk("R3",  "status_exl", {31'b0, status_exl}, {31'b0, m_exl});
    chk("R12", "status_bev", {31'b0, status_bev}, {31'b0, m_bev});
    chk("R4",  "css", {28'b0, css}, {28'b0, m_css});
    chk("R4",  "pss", {28'b0, pss}, {28'b0, m_pss});
    chk("R4",  "ess", {28'b0, ess}, {28'b0, m_ess});
    chk("R11", "ebase", ebase, m_ebase);
    chk("R9",  "badvaddr", badvaddr, m_bva);
    chk("R9",  "ehi_vpn2", {13'b0, ehi_vpn2}, {13'b0, m_vpn2});
    chk("R9",  "ehi_asid", {24'b0, ehi_asid}, {24'b0, m_asid});
    chk("R9",  "ctx_vpn2", {13'b0, ctx_vpn2}, {13'b0, m_ctx});
  endtask

  task automatic model_write(logic [1:0] s, logic [31:0] d);
    case (s)
      0: begin m_exl = d[0]; m_bev = d[1]; end
      1: m_iv = d[0];
      2: begin m_ess = d[3:0]; m_css = d[7:4]; m_pss = d[11:8]; end
      3: m_ebase = {2'b10, d[29:12], 12'h000};
    endcase
  endtask

  task automatic model_exc(logic [3:0] k, logic [31:0] pc, logic [31:0] npc,
                           logic [31:0] bva, logic [7:0] asid, logic [1:0] cop);
    logic slot;
    if (k >= 14) begin m_pend = 0; return; end
    slot = (pc + 32'd4) != npc;
    m_pend = 1;
    m_pc = vec_of(k, m_exl, m_bev, m_iv, m_ebase);
    m_epc = slot ? pc - 32'd4 : pc;
    m_bd = slot;
    m_code = code_of(k);
    m_ce = (k == 11) ? cop : 2'b0;
    if (!m_exl && !m_bev) begin m_pss = m_css; m_css = m_ess; end
    m_exl = 1;
    if (k <= 6) m_bva = bva;
    if (k <= 4) begin m_vpn2 = bva[31:13]; m_ctx = bva[31:13]; m_asid = asid; end
  endtask

  task automatic do_exc(logic [3:0] k, logic [31:0] pc, logic [31:0] npc,
                        logic [31:0] bva, logic [7:0] asid, logic [1:0] cop,
                        bit with_wr = 0, logic [1:0] s = 0, logic [31:0] d = 0);
    kind = k; pc_in = pc; npc_in = npc; bad_vaddr = bva; asid_in = asid;
    cop_num = cop; req = 1; wr_en = with_wr; wr_sel = s; wr_data = d;
    @(negedge clk);
    req = 0; wr_en = 0;
    model_exc(k, pc, npc, bva, asid, cop);
    if (k >= 14 && with_wr) model_write(s, d);
    check_all(k >= 14 ? "R13" : vtag(k));
  endtask

  task automatic do_wr(logic [1:0] s, logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    m_pend = 0;
    model_write(s, d);
    check_all("R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    reset_model();
    repeat (3) @(negedge clk);
    check_all("R11");
    rst_n = 1;
    @(negedge clk);
    check_all("R11");

    // R8: overflow with bootstrap bit set (reset state)
    do_exc(12, 32'h00400100, 32'h00400104, 0, 0, 0);
    // R10: pending lasts one cycle
    @(negedge clk); m_pend = 0; check_all("R10");
    // R6: first-level refill then nested refill
    do_wr(3, 32'h12345000);
    do_wr(0, 32'h0);
    do_exc(1, 32'h00401000, 32'h00401004, 32'hDEADB123, 8'h5A, 0);
    do_exc(2, 32'h00401010, 32'h00402000, 32'h7000E000, 8'h11, 0);
    // R7: vectored interrupt, R5 coprocessor number
    do_wr(1, 32'h1);
    do_exc(9, 32'h00500000, 32'h00500004, 0, 0, 0);
    do_wr(2, 32'h00000A53);
    do_wr(0, 32'h0);
    do_exc(11, 32'h00500020, 32'h00500024, 0, 0, 2'd3);
    // R12: write colliding with a fault is dropped
    do_exc(7, 32'h00600000, 32'h00600004, 0, 0, 0, 1, 2'd0, 32'h0);
    // R13: invalid kinds ignored
    do_exc(14, 32'h00700000, 32'h00700010, 32'hFFFFFFFF, 8'hFF, 2'd1);
    do_exc(15, 32'h00700000, 32'h00700004, 32'h12345678, 8'h01, 2'd2);
    // R2: wrap of pc+4 at top of address space
    do_exc(13, 32'hFFFFFFFC, 32'h00000000, 0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [1:0] s = 2'($urandom_range(0, 3));
        do_wr(s, $urandom);
      end else begin
        logic [31:0] pc = $urandom & 32'hFFFFFFFC;
        logic [31:0] npc = ($urandom_range(0, 2) == 0) ? ($urandom & 32'hFFFFFFFC) : pc + 4;
        do_exc(4'($urandom_range(0, 15)), pc, npc, $urandom, 8'($urandom),
               2'($urandom), $urandom_range(0, 3) == 0, 2'($urandom), $urandom);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule